// File: doc/BRIEF.md
# Banked Internal RAM with Bit Addressing

This block is the on-chip scratch memory of a small 8-bit core. One byte array can be reached in three ways. Direct accesses use an 8-bit byte address. Working-register accesses give a register number, and the current bank picks which group of eight bytes that number lands in. Single-bit accesses set, clear or read one bit inside a dedicated bit-addressable segment.

All reads are combinational: they show the stored contents in the same cycle the address is presented. All writes, including the read-modify-write of a bit operation, take effect at the next rising clock edge. Bad addresses raise error flags and change nothing. When a direct byte write lands on the same byte as a register write or a bit write in the same cycle, the byte write is kept and a conflict flag is raised.

The banks sit at the bottom of the array. The bit segment starts on the byte just above the last bank. The bank number is the only state that is reset. Memory contents are undefined until written.

Top module: `iram_banked`

## Requirements
- R1: For `byte_addr` below `BYTES` (128), `byte_rdata` shows the stored byte in the same cycle. When `byte_we` is high, `byte_wdata` is stored at that address at the next rising edge.
- R2: For `byte_addr` of `BYTES` or above, `byte_err` is high and `byte_rdata` is 0. A write to such an address changes no byte.
- R3: Register number n of the current bank b maps to byte b*8+n, so the four banks cover bytes 0 to 31. `reg_rdata` shows that byte in the same cycle. With `reg_we` high, `reg_wdata` is stored there at the next edge.
- R4: The current bank `cur_bank` is 0 after reset. When `bank_we` is high, it loads `bank_in` at the next edge.
- R5: Bit address a selects byte 32 + a[7:3] and bit a[2:0] of that byte. While that byte lies inside the segment, `bit_rdata` shows the selected bit in the same cycle, whatever the operation code.
- R6: `bit_op` encoding is 00 none, 01 set, 10 clear and 11 read. Set forces the selected bit to 1 and clear forces it to 0 at the next edge. The other seven bits of the byte keep their values.
- R7: A bit address with a[7:3] at or above `SEG_BYTES` is out of range. With a nonzero `bit_op`, `bit_err` is high. For any out-of-range bit address, `bit_rdata` is 0 and no byte changes.
- R8: When a valid byte write and a register write, or a valid set/clear, target the same byte in the same cycle, `wr_conflict` is high and the byte ends up holding `byte_wdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset of the bank number |
| byte_addr | input | 8 | Direct byte address |
| byte_we | input | 1 | Direct byte write enable |
| byte_wdata | input | 8 | Direct write data |
| byte_rdata | output | 8 | Direct read data, same cycle |
| byte_err | output | 1 | Byte address out of range |
| bank_we | input | 1 | Load a new bank number |
| bank_in | input | 2 | New bank number |
| cur_bank | output | 2 | Current bank number |
| reg_num | input | 3 | Register number within the bank |
| reg_we | input | 1 | Register write enable |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, same cycle |
| bit_addr | input | 8 | Bit address |
| bit_op | input | 2 | Bit operation: 00 none, 01 set, 10 clear, 11 read |
| bit_rdata | output | 1 | Addressed bit, same cycle |
| bit_err | output | 1 | Bit address beyond the segment |
| wr_conflict | output | 1 | Byte write overrode a register or bit write |

## Verification
The bench builds the block with `SEG_BYTES` set to 16 instead of 32. The segment then covers bytes 32 to 47, and bit addresses 128 to 255 are out of range. With the default of 32, every 8-bit bit address is legal, so the range error could never be provoked. The narrower segment also leaves bytes 48 to 127 outside it, so a bench check can detect a bit operation that wraps or aliases into them. The other parameters keep their defaults (128 bytes, four banks of eight registers).

// File: rtl/iram_pkg.sv
package iram_pkg;

    typedef enum logic [1:0] {
        BIT_NOP = 2'b00,
        BIT_SET = 2'b01,
        BIT_CLR = 2'b10,
        BIT_RD  = 2'b11
    } bit_op_e;

    function automatic logic op_writes(input bit_op_e op);
        return (op == BIT_SET) || (op == BIT_CLR);
    endfunction

endpackage

// File: rtl/iram_addr_map.sv
module iram_addr_map #(
    parameter int BYTES      = 128,
    parameter int BANKS      = 4,
    parameter int REGS       = 8,
    parameter int SEG_BYTES  = 32,
    parameter int ADDR_W     = 8,
    localparam int IDX_W     = $clog2(BYTES),
    localparam int BANK_W    = $clog2(BANKS),
    localparam int RNUM_W    = $clog2(REGS),
    localparam int SEG_BASE  = BANKS * REGS
) (
    input  logic [ADDR_W-1:0] byte_addr,
    input  logic [BANK_W-1:0] bank,
    input  logic [RNUM_W-1:0] reg_num,
    input  logic [ADDR_W-1:0] bit_addr,
    output logic              byte_ok,
    output logic [IDX_W-1:0]  byte_idx,
    output logic [IDX_W-1:0]  reg_idx,
    output logic              bit_ok,
    output logic [IDX_W-1:0]  bit_byte,
    output logic [2:0]        bit_idx
);
    logic [ADDR_W-4:0] seg_off;

    always_comb begin
        byte_ok  = int'(byte_addr) < BYTES;
        byte_idx = byte_addr[IDX_W-1:0];
        reg_idx  = IDX_W'(bank) * IDX_W'(REGS) + IDX_W'(reg_num);
        seg_off  = bit_addr[ADDR_W-1:3];
        bit_ok   = int'(seg_off) < SEG_BYTES;
        bit_byte = IDX_W'(SEG_BASE) + IDX_W'(seg_off);
        bit_idx  = bit_addr[2:0];
    end

endmodule

// File: rtl/iram_bit_rmw.sv
module iram_bit_rmw
    import iram_pkg::*;
(
    input  logic [7:0] old_byte,
    input  logic [2:0] bit_idx,
    input  bit_op_e    op,
    output logic [7:0] new_byte,
    output logic       cur_bit
);
    logic [7:0] mask;

    always_comb begin
        mask    = 8'b1 << bit_idx;
        cur_bit = |(old_byte & mask);
        unique case (op)
            BIT_SET: new_byte = old_byte | mask;
            BIT_CLR: new_byte = old_byte & ~mask;
            default: new_byte = old_byte;
        endcase
    end

endmodule

// File: rtl/iram_write_arb.sv
module iram_write_arb #(
    parameter int IDX_W = 7
) (
    input  logic             byte_wr,
    input  logic [IDX_W-1:0] byte_idx,
    input  logic             reg_wr,
    input  logic [IDX_W-1:0] reg_idx,
    input  logic             bit_wr,
    input  logic [IDX_W-1:0] bit_byte,
    output logic             reg_keep,
    output logic             bit_keep,
    output logic             conflict
);
    logic reg_hit;
    logic bit_hit;

    always_comb begin
        reg_hit  = byte_wr && reg_wr && (reg_idx == byte_idx);
        bit_hit  = byte_wr && bit_wr && (bit_byte == byte_idx);
        reg_keep = reg_wr && !reg_hit;
        bit_keep = bit_wr && !bit_hit;
        conflict = reg_hit || bit_hit;
    end

endmodule

// File: rtl/iram_banked.sv
module iram_banked
    import iram_pkg::*;
#(
    parameter int BYTES     = 128,
    parameter int BANKS     = 4,
    parameter int REGS      = 8,
    parameter int SEG_BYTES = 32,
    parameter int ADDR_W    = 8,
    localparam int IDX_W    = $clog2(BYTES),
    localparam int BANK_W   = $clog2(BANKS),
    localparam int RNUM_W   = $clog2(REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] byte_addr,
    input  logic              byte_we,
    input  logic [7:0]        byte_wdata,
    output logic [7:0]        byte_rdata,
    output logic              byte_err,
    input  logic              bank_we,
    input  logic [BANK_W-1:0] bank_in,
    output logic [BANK_W-1:0] cur_bank,
    input  logic [RNUM_W-1:0] reg_num,
    input  logic              reg_we,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic [ADDR_W-1:0] bit_addr,
    input  logic [1:0]        bit_op,
    output logic              bit_rdata,
    output logic              bit_err,
    output logic              wr_conflict
);
    typedef struct packed {
        logic [BYTES-1:0][7:0] mem;
        logic [BANK_W-1:0]     bank;
    } state_t;

    state_t st_d, st_q;

    logic             byte_ok, bit_ok;
    logic [IDX_W-1:0] byte_idx, reg_idx, bit_byte;
    logic [2:0]       bit_idx;
    logic [7:0]       rmw_new;
    logic             rmw_bit;
    logic             byte_wr, bit_wr;
    logic             reg_keep, bit_keep;
    bit_op_e          op;

    assign op = bit_op_e'(bit_op);

    iram_addr_map #(
        .BYTES(BYTES), .BANKS(BANKS), .REGS(REGS),
        .SEG_BYTES(SEG_BYTES), .ADDR_W(ADDR_W)
    ) i_map (
        .byte_addr(byte_addr), .bank(st_q.bank), .reg_num(reg_num),
        .bit_addr(bit_addr), .byte_ok(byte_ok), .byte_idx(byte_idx),
        .reg_idx(reg_idx), .bit_ok(bit_ok), .bit_byte(bit_byte),
        .bit_idx(bit_idx)
    );

    iram_bit_rmw i_rmw (
        .old_byte(st_q.mem[bit_byte]), .bit_idx(bit_idx), .op(op),
        .new_byte(rmw_new), .cur_bit(rmw_bit)
    );

    assign byte_wr = byte_we && byte_ok;
    assign bit_wr  = op_writes(op) && bit_ok;

    iram_write_arb #(.IDX_W(IDX_W)) i_arb (
        .byte_wr(byte_wr), .byte_idx(byte_idx),
        .reg_wr(reg_we), .reg_idx(reg_idx),
        .bit_wr(bit_wr), .bit_byte(bit_byte),
        .reg_keep(reg_keep), .bit_keep(bit_keep), .conflict(wr_conflict)
    );

    // Read side: all same-cycle views of the registered array.
    always_comb begin
        byte_err   = !byte_ok;
        byte_rdata = byte_ok ? st_q.mem[byte_idx] : 8'h00;
        reg_rdata  = st_q.mem[reg_idx];
        bit_rdata  = bit_ok && rmw_bit;
        bit_err    = !bit_ok && (op != BIT_NOP);
        cur_bank   = st_q.bank;
    end

    // Next state: lowest priority applied first so the byte port overrides.
    always_comb begin
        st_d = st_q;
        if (bank_we)  st_d.bank = bank_in;
        if (bit_keep) st_d.mem[bit_byte] = rmw_new;
        if (reg_keep) st_d.mem[reg_idx] = reg_wdata;
        if (byte_wr)  st_d.mem[byte_idx] = byte_wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.bank <= '0;
            st_q.mem  <= st_d.mem;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/iram_checker.sv
module iram_checker #(
    parameter int BYTES     = 128,
    parameter int SEG_BYTES = 32
) (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] byte_addr,
    input logic       byte_we,
    input logic [7:0] byte_wdata,
    input logic [7:0] byte_rdata,
    input logic       byte_err,
    input logic       bank_we,
    input logic [1:0] bank_in,
    input logic [1:0] cur_bank,
    input logic [7:0] bit_addr,
    input logic [1:0] bit_op,
    input logic       bit_rdata,
    input logic       bit_err,
    input logic       wr_conflict
);
    assert_byte_store_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_we && !byte_err) |=>
        ((byte_addr != $past(byte_addr)) || (byte_rdata == $past(byte_wdata))));

    assert_bad_byte_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(byte_addr) >= BYTES) |-> (byte_err && byte_rdata == 8'h00));

    assert_bank_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        bank_we |=> (cur_bank == $past(bank_in)));

    assert_bank_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !bank_we |=> $stable(cur_bank));

    assert_bit_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_op == 2'b01 && !bit_err && !wr_conflict) |=>
        ((bit_addr != $past(bit_addr)) || bit_rdata));

    assert_bit_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_op == 2'b10 && !bit_err && !wr_conflict) |=>
        ((bit_addr != $past(bit_addr)) || !bit_rdata));

    assert_bit_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(bit_addr[7:3]) >= SEG_BYTES && bit_op != 2'b00) |->
        (bit_err && !bit_rdata));

    assert_conflict_needs_byte_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_conflict |-> (byte_we && !byte_err));

    assert_conflict_byte_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_conflict |=>
        ((byte_addr != $past(byte_addr)) || (byte_rdata == $past(byte_wdata))));

endmodule

bind iram_banked iram_checker #(.BYTES(BYTES), .SEG_BYTES(SEG_BYTES)) i_chk (
    .clk(clk), .rst_n(rst_n), .byte_addr(byte_addr), .byte_we(byte_we),
    .byte_wdata(byte_wdata), .byte_rdata(byte_rdata), .byte_err(byte_err),
    .bank_we(bank_we), .bank_in(bank_in), .cur_bank(cur_bank),
    .bit_addr(bit_addr), .bit_op(bit_op), .bit_rdata(bit_rdata),
    .bit_err(bit_err), .wr_conflict(wr_conflict)
);

// File: tb/test_iram_banked.sv
`timescale 1ns/1ps
module test_iram_banked;
    localparam int SEG = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] byte_addr = '0;
    logic       byte_we = 1'b0;
    logic [7:0] byte_wdata = '0;
    logic [7:0] byte_rdata;
    logic       byte_err;
    logic       bank_we = 1'b0;
    logic [1:0] bank_in = '0;
    logic [1:0] cur_bank;
    logic [2:0] reg_num = '0;
    logic       reg_we = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic [7:0] bit_addr = '0;
    logic [1:0] bit_op = '0;
    logic       bit_rdata;
    logic       bit_err;
    logic       wr_conflict;

    iram_banked #(.SEG_BYTES(SEG)) i_iram_banked (
        .clk(clk), .rst_n(rst_n),
        .byte_addr(byte_addr), .byte_we(byte_we), .byte_wdata(byte_wdata),
        .byte_rdata(byte_rdata), .byte_err(byte_err),
        .bank_we(bank_we), .bank_in(bank_in), .cur_bank(cur_bank),
        .reg_num(reg_num), .reg_we(reg_we), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .bit_addr(bit_addr), .bit_op(bit_op), .bit_rdata(bit_rdata),
        .bit_err(bit_err), .wr_conflict(wr_conflict)
    );

    always #2.5 clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // Behavioural reference: flat byte list plus "written yet" flags.
    int unsigned ref_mem[128];
    bit          ref_known[128];
    int          ref_bank = 0;

    function automatic void chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endfunction

    function automatic void compare_all();
        int ba, ri, sb, sbit;
        bit in_seg, exp_conf;
        ba = int'(byte_addr);
        chk("R2 byte_err", int'(byte_err), int'(ba >= 128));
        if (ba >= 128) chk("R2 byte_rdata", int'(byte_rdata), 0);
        else if (ref_known[ba]) chk("R1 byte_rdata", int'(byte_rdata), int'(ref_mem[ba]));
        chk("R4 cur_bank", int'(cur_bank), ref_bank);
        ri = ref_bank * 8 + int'(reg_num);
        if (ref_known[ri]) chk("R3 reg_rdata", int'(reg_rdata), int'(ref_mem[ri]));
        in_seg = (int'(bit_addr) / 8) < SEG;
        sb = 32 + int'(bit_addr) / 8;
        sbit = int'(bit_addr) % 8;
        chk("R7 bit_err", int'(bit_err), int'(!in_seg && bit_op != 2'b00));
        if (!in_seg) chk("R7 bit_rdata", int'(bit_rdata), 0);
        else if (ref_known[sb]) chk("R5 bit_rdata", int'(bit_rdata), int'((ref_mem[sb] >> sbit) & 1));
        exp_conf = byte_we && ba < 128 &&
                   ((reg_we && ri == ba) ||
                    ((bit_op == 2'b01 || bit_op == 2'b10) && in_seg && sb == ba));
        chk("R8 wr_conflict", int'(wr_conflict), int'(exp_conf));
    endfunction

    function automatic void update_model(int ba, bit bwe, int bwd, bit kwe, int kin,
                                         int rn, bit rwe, int rwd, int xa, int xop);
        int ri, sb;
        bit in_seg;
        ri = ref_bank * 8 + rn;
        sb = 32 + xa / 8;
        in_seg = (xa / 8) < SEG;
        if (in_seg && (xop == 1 || xop == 2) && !(bwe && ba == sb)) begin
            if (xop == 1) ref_mem[sb] = ref_mem[sb] | (32'd1 << (xa % 8));
            else          ref_mem[sb] = ref_mem[sb] & ~(32'd1 << (xa % 8));
        end
        if (rwe && !(bwe && ba < 128 && ba == ri)) begin
            ref_mem[ri] = rwd; ref_known[ri] = 1'b1;
        end
        if (bwe && ba < 128) begin
            ref_mem[ba] = bwd; ref_known[ba] = 1'b1;
        end
        if (kwe) ref_bank = kin;
    endfunction

    task automatic step();
        int ba, bwd, kin, rn, rwd, xa, xop;
        bit bwe, kwe, rwe;
        #1;
        compare_all();
        ba = int'(byte_addr); bwe = byte_we; bwd = int'(byte_wdata);
        kwe = bank_we; kin = int'(bank_in);
        rn = int'(reg_num); rwe = reg_we; rwd = int'(reg_wdata);
        xa = int'(bit_addr); xop = int'(bit_op);
        @(posedge clk);
        update_model(ba, bwe, bwd, kwe, kin, rn, rwe, rwd, xa, xop);
        @(negedge clk);
    endtask

    task automatic drive(int ba, bit bwe, int bwd, bit kwe, int kin,
                         int rn, bit rwe, int rwd, int xa, int xop);
        byte_addr = 8'(ba); byte_we = bwe; byte_wdata = 8'(bwd);
        bank_we = kwe; bank_in = 2'(kin);
        reg_num = 3'(rn); reg_we = rwe; reg_wdata = 8'(rwd);
        bit_addr = 8'(xa); bit_op = 2'(xop);
    endtask

    // Read a byte through the byte port and check it against a literal value.
    task automatic peek(int ba, int exp, string tag);
        drive(ba, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        #1;
        chk(tag, int'(byte_rdata), exp);
        step();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R4 bank after reset", int'(cur_bank), 0);
        @(negedge clk);

        for (int i = 0; i < 128; i++) begin
            drive(i, 1, (i * 37 + 5) & 255, 0, 0, 0, 0, 0, 0, 0);
            step();
        end

        // R3/R4: bank switch then register write/read
        drive(0, 0, 0, 1, 2, 0, 0, 0, 0, 0); step();
        #1; chk("R4 bank loaded", int'(cur_bank), 2);
        drive(0, 0, 0, 0, 0, 5, 1, 8'hC3, 0, 0); step();
        peek(21, 8'hC3, "R3 bank2 reg5 at byte 21");
        drive(0, 0, 0, 1, 3, 0, 0, 0, 0, 0); step();
        drive(0, 0, 0, 0, 0, 7, 1, 8'h3C, 0, 0); step();
        peek(31, 8'h3C, "R3 bank3 reg7 at byte 31");

        // R2: out-of-range write does not alias
        drive(200, 1, 8'h5A, 0, 0, 0, 0, 0, 0, 0); step();
        peek(72, (72 * 37 + 5) & 255, "R2 no alias at byte 72");

        // R6: set and clear one bit of byte 34
        drive(34, 1, 8'hA5, 0, 0, 0, 0, 0, 0, 0); step();
        drive(0, 0, 0, 0, 0, 0, 0, 0, 17, 1); step();
        peek(34, 8'hA7, "R6 set bit1 of byte 34");
        drive(0, 0, 0, 0, 0, 0, 0, 0, 21, 2); step();
        peek(34, 8'h87, "R6 clear bit5 of byte 34");
        drive(0, 0, 0, 0, 0, 0, 0, 0, 127, 1); step();
        peek(47, ((47 * 37 + 5) & 255) | 8'h80, "R6 set top bit of last segment byte");

        // R7: out-of-range set must not touch byte 57
        drive(0, 0, 0, 0, 0, 0, 0, 0, 200, 1); step();
        peek(57, (57 * 37 + 5) & 255, "R7 no alias at byte 57");

        // R8: byte write against bit write, then against register write
        drive(34, 1, 8'h11, 0, 0, 0, 0, 0, 16, 1); step();
        peek(34, 8'h11, "R8 byte beats bit");
        drive(0, 0, 0, 1, 1, 0, 0, 0, 0, 0); step();
        drive(10, 1, 8'h22, 0, 0, 2, 1, 8'h33, 0, 0); step();
        peek(10, 8'h22, "R8 byte beats register");

        // Mixed traffic against the reference model
        for (int i = 0; i < 3000; i++) begin
            int ba, xa;
            xa = int'($urandom % 160);
            if ($urandom % 5 == 0) ba = 32 + xa / 8;
            else ba = int'($urandom % 144);
            drive(ba, ($urandom % 3) == 0, int'($urandom % 256),
                  ($urandom % 8) == 0, int'($urandom % 4),
                  int'($urandom % 8), ($urandom % 3) == 0, int'($urandom % 256),
                  xa, int'($urandom % 4));
            step();
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL all requirements: watchdog actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule